// File: doc/BRIEF.md
# Local Bus Transfer Sequencer

This block is a self-running state machine that carries out transfers on a local peripheral bus for requests arriving from a host-side decoder. Each request names a direction, a set of byte lanes, one of several address regions and whether it is a lone transfer or one beat of a burst. The sequencer then places an address on the local bus, waits a programmable number of cycles, pulses a read or write strobe and reports completion to the requester. No external control logic is needed.

Every region has its own configured data width of 8, 16 or 32 bits. A 32-bit request to a narrow region is carried out as up to four or two local cycles, lowest byte first. Cycles whose byte lanes are all disabled are skipped. Read bytes are gathered back into their original lane positions. When the sequencer is switched to passive operation it ignores requests, and external logic owns the bus.

Burst beats after the first take their address from an internal pointer that moves up one full word per beat. The region width and wait count are latched when a burst or single request starts, and they hold until the request ends.

Top module: `lbus_seq`

## Requirements
- R1: While reset is held, and in the cycles after its release with no request, `lb_rd`, `lb_wr` and `req_done` are low and `lb_addr` is zero.
- R2: When `active_mode` is 0, a request pulse is ignored. No strobe and no `req_done` follow, and the next request accepted with `active_mode` at 1 is handled normally.
- R3: Each local cycle holds its address for one setup cycle, then for exactly `wait_cfg` (0 to 7) wait cycles, then for one strobe cycle. With a count of 0 the strobe follows the setup cycle directly. The j-th executed local cycle (counted from 0) therefore strobes in cycle 2 + j*(W+2) + W after the accepting edge, where cycle 1 is the first cycle after that edge.
- R4: The width code of region r is `width_cfg[2r+1:2r]`: 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. A request is split into 4, 2 or 1 slots of that width, which are visited in ascending order. Slot s drives `lb_addr` = base + s*(slot bytes).
- R5: A slot whose request byte enables are all 0 gets no local cycle. A request with all byte enables 0 raises `req_done` in cycle 1 and produces no strobe.
- R6: During a write strobe for slot s with byte offset o = s*(slot bytes), `lb_wdata` equals the request data shifted right by 8*o bits. `lb_be` equals the request byte enables shifted right by o, masked to the slot width.
- R7: When `req_done` rises after a read, each byte of `req_rdata` in an executed slot holds the matching low byte of `lb_rdata` captured at that slot's strobe, placed at its original lane position. Bytes of skipped slots are 0.
- R8: `req_done` is high for exactly one cycle, the cycle after the last strobe, which is cycle n*(W+2)+1 for n executed slots.
- R9: After a burst beat without the last flag, the next accepted beat ignores `req_addr` and `req_region` and uses base = previous base + 4. The region width and wait count of the first beat stay in force until the beat that carries the last flag has finished.
- R10: Changes to `wait_cfg` or `width_cfg` during a transfer do not alter that transfer's timing, addresses or data.
- R11: A write drives only `lb_wr` and a read drives only `lb_rd`, and never both at once. A `req_valid` pulse while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| active_mode | input | 1 | 1: sequencer drives the local bus; 0: passive, requests ignored |
| wait_cfg | input | WAIT_W (3) | Wait cycles per local cycle, 0 to 7 |
| width_cfg | input | 2*REGIONS (8) | Two-bit width code per region |
| req_valid | input | 1 | One-cycle request pulse, taken when the sequencer is idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_be | input | 4 | Request byte enables, bit b for byte lane b |
| req_region | input | RSEL_W (2) | Targeted region |
| req_burst | input | 1 | Request is a burst beat |
| req_last | input | 1 | Beat is the final one of its burst |
| req_addr | input | ADDR_W (29) | Byte address of a single request or a first burst beat |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Gathered read data, valid with req_done |
| req_done | output | 1 | One-cycle completion pulse |
| lb_addr | output | ADDR_W (29) | Local bus address |
| lb_rd | output | 1 | Local read strobe |
| lb_wr | output | 1 | Local write strobe |
| lb_be | output | 4 | Local byte enables, low-aligned |
| lb_wdata | output | 32 | Local write data, low-aligned |
| lb_rdata | input | 32 | Local read data, sampled at the read strobe |

## Verification
The results come at fixed offsets from the edge that accepts a request. The j-th strobe comes in cycle 2 + j*(W+2) + W, and `req_done` with the gathered read data comes in cycle n*(W+2)+1, or in cycle 1 when no slot is enabled. The bench drives a request at a falling edge, counts falling edges after the accepting rising edge, and compares each strobe's cycle number, address, enables and data against values worked out from the slot arithmetic. A sweep covers every wait count, every region width, every byte-enable pattern and both directions. Directed runs cover passive mode, a pulse and configuration changes during a transfer, and a three-beat burst followed by a single request.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  localparam int unsigned LANES = 4;
  localparam int unsigned DW    = 8 * LANES;
  localparam int unsigned IDX_W = $clog2(LANES);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_STROBE = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_e;

  // Width code to log2 of bytes per local cycle.
  function automatic logic [1:0] code2lg(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/lbus_lane_plan.sv
module lbus_lane_plan #(
  parameter  int unsigned LN = lbus_pkg::LANES,
  localparam int unsigned IW = $clog2(LN)
) (
  input  logic [1:0]    wid_lg,
  input  logic [LN-1:0] be,
  input  logic [IW-1:0] cur_idx,
  output logic [LN-1:0] slot_used,
  output logic          first_vld,
  output logic [IW-1:0] first_idx,
  output logic          next_vld,
  output logic [IW-1:0] next_idx
);

  always_comb begin
    slot_used = '0;
    for (int b = 0; b < LN; b++) begin
      slot_used[IW'(b) >> wid_lg] = slot_used[IW'(b) >> wid_lg] | be[b];
    end
  end

  always_comb begin
    first_vld = 1'b0;
    first_idx = '0;
    next_vld  = 1'b0;
    next_idx  = '0;
    for (int s = LN - 1; s >= 0; s--) begin
      if (slot_used[s]) begin
        first_vld = 1'b1;
        first_idx = IW'(s);
      end
      if (slot_used[s] && (IW'(s) > cur_idx)) begin
        next_vld = 1'b1;
        next_idx = IW'(s);
      end
    end
  end

endmodule

// File: rtl/lbus_lane_mux.sv
module lbus_lane_mux #(
  parameter  int unsigned LN = lbus_pkg::LANES,
  localparam int unsigned IW = $clog2(LN),
  localparam int unsigned W  = 8 * LN
) (
  input  logic [1:0]    wid_lg,
  input  logic [IW-1:0] idx,
  input  logic [LN-1:0] be,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  rdata,
  input  logic [W-1:0]  acc,
  output logic [IW-1:0] off,
  output logic [LN-1:0] lane_be,
  output logic [W-1:0]  lane_wdata,
  output logic [W-1:0]  acc_next
);

  logic [LN-1:0] slot_mask;
  logic [W-1:0]  rd_shift;

  assign off        = idx << wid_lg;
  assign slot_mask  = LN'((1 << (1 << wid_lg)) - 1);
  assign lane_be    = (be >> off) & slot_mask;
  assign lane_wdata = wdata >> (8 * off);
  assign rd_shift   = rdata << (8 * off);

  for (genvar b = 0; b < LN; b++) begin : g_byte
    assign acc_next[8*b +: 8] = ((IW'(b) >> wid_lg) == idx) ? rd_shift[8*b +: 8]
                                                            : acc[8*b +: 8];
  end

endmodule

// File: rtl/lbus_wait_ctr.sv
module lbus_wait_ctr #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt_q,
  output logic         last
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(1));

  AST_WAIT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    dec |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
#(
  parameter  int unsigned ADDR_W  = 29,
  parameter  int unsigned REGIONS = 4,
  parameter  int unsigned WAIT_W  = 3,
  localparam int unsigned RSEL_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active_mode,
  input  logic [WAIT_W-1:0]    wait_cfg,
  input  logic [2*REGIONS-1:0] width_cfg,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [LANES-1:0]     req_be,
  input  logic [RSEL_W-1:0]    req_region,
  input  logic                 req_burst,
  input  logic                 req_last,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic [DW-1:0]        req_rdata,
  output logic                 req_done,
  output logic [ADDR_W-1:0]    lb_addr,
  output logic                 lb_rd,
  output logic                 lb_wr,
  output logic [LANES-1:0]     lb_be,
  output logic [DW-1:0]        lb_wdata,
  input  logic [DW-1:0]        lb_rdata
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  seq_state_e state_q, state_d;

  logic               ctx_write, ctx_burst, ctx_last;
  logic [LANES-1:0]   ctx_be;
  logic [DW-1:0]      ctx_wdata;
  logic [WAIT_W-1:0]  ctx_wait;
  logic [1:0]         ctx_wid;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic               in_burst_q;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DW-1:0]      acc_q, acc_d;

  logic               accept;
  logic               is_idle;
  logic [1:0]         reg_code;
  logic [1:0]         new_wid;
  logic [WAIT_W-1:0]  new_wait;
  logic [1:0]         plan_wid;
  logic [LANES-1:0]   plan_be;
  logic [LANES-1:0]   slot_used;
  logic               first_vld, next_vld;
  logic [IDX_W-1:0]   first_idx, next_idx;
  logic [IDX_W-1:0]   lane_off;
  logic [DW-1:0]      acc_merged;
  logic               wc_last;
  logic [WAIT_W-1:0]  wc_cnt;

  assign is_idle = (state_q == ST_IDLE);
  assign accept  = is_idle && req_valid && active_mode;

  // Region width lookup.
  always_comb begin
    reg_code = '0;
    for (int r = 0; r < REGIONS; r++) begin
      if (req_region == RSEL_W'(r)) reg_code = width_cfg[2*r +: 2];
    end
  end

  assign new_wid  = in_burst_q ? ctx_wid  : code2lg(reg_code);
  assign new_wait = in_burst_q ? ctx_wait : wait_cfg;
  assign plan_wid = is_idle ? new_wid : ctx_wid;
  assign plan_be  = is_idle ? req_be  : ctx_be;

  lbus_lane_plan #(.LN(LANES)) u_plan (
    .wid_lg    (plan_wid),
    .be        (plan_be),
    .cur_idx   (idx_q),
    .slot_used (slot_used),
    .first_vld (first_vld),
    .first_idx (first_idx),
    .next_vld  (next_vld),
    .next_idx  (next_idx)
  );

  lbus_lane_mux #(.LN(LANES)) u_mux (
    .wid_lg     (ctx_wid),
    .idx        (idx_q),
    .be         (ctx_be),
    .wdata      (ctx_wdata),
    .rdata      (lb_rdata),
    .acc        (acc_q),
    .off        (lane_off),
    .lane_be    (lb_be),
    .lane_wdata (lb_wdata),
    .acc_next   (acc_merged)
  );

  lbus_wait_ctr #(.W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (state_q == ST_ADDR),
    .load_val (ctx_wait),
    .dec      (state_q == ST_WAIT),
    .cnt_q    (wc_cnt),
    .last     (wc_last)
  );

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = first_vld ? ST_ADDR : ST_DONE;
      ST_ADDR:   state_d = (ctx_wait == '0) ? ST_STROBE : ST_WAIT;
      ST_WAIT:   if (wc_last) state_d = ST_STROBE;
      ST_STROBE: state_d = next_vld ? ST_ADDR : ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    idx_d = idx_q;
    if (accept)                               idx_d = first_idx;
    else if (state_q == ST_STROBE && next_vld) idx_d = next_idx;
  end

  always_comb begin
    acc_d = acc_q;
    if (accept)                                  acc_d = '0;
    else if (state_q == ST_STROBE && !ctx_write) acc_d = acc_merged;
  end

  assign base_d = in_burst_q ? (base_q + ADDR_W'(LANES)) : req_addr;

  // Registers.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      acc_q   <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_write <= 1'b0;
      ctx_burst <= 1'b0;
      ctx_last  <= 1'b0;
      ctx_be    <= '0;
      ctx_wdata <= '0;
      ctx_wait  <= '0;
      ctx_wid   <= '0;
      base_q    <= '0;
    end else if (accept) begin
      ctx_write <= req_write;
      ctx_burst <= req_burst;
      ctx_last  <= req_last;
      ctx_be    <= req_be;
      ctx_wdata <= req_wdata;
      ctx_wait  <= new_wait;
      ctx_wid   <= new_wid;
      base_q    <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                 in_burst_q <= 1'b0;
    else if (state_q == ST_DONE) in_burst_q <= ctx_burst && !ctx_last;
  end

  // Outputs.
  assign lb_addr   = base_q + ADDR_W'(lane_off);
  assign lb_rd     = (state_q == ST_STROBE) && !ctx_write;
  assign lb_wr     = (state_q == ST_STROBE) &&  ctx_write;
  assign req_done  = (state_q == ST_DONE);
  assign req_rdata = acc_q;

  // Independent count of wait cycles for checking.
  logic [WAIT_W-1:0] wseen_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                  wseen_q <= '0;
    else if (state_q == ST_ADDR)  wseen_q <= '0;
    else if (state_q == ST_WAIT)  wseen_q <= wseen_q + WAIT_W'(1);
  end

  AST_WAIT_EXACT: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_STROBE) |-> (wseen_q == ctx_wait)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_WAIT || state_q == ST_STROBE) |-> $stable(lb_addr)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(lb_rd && lb_wr)); // R11
  AST_PASSIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_idle && req_valid && !active_mode) |=> (state_q == ST_IDLE)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    req_done |=> !req_done); // R8
  AST_STROBE_USED: assert property (@(posedge clk) disable iff (!rst_ni)
    (lb_rd || lb_wr) |-> (lb_be != '0)); // R5

endmodule

// File: tb/lbus_seq_bench.sv
module lbus_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        active_mode;
  logic [2:0]  wait_cfg;
  logic [7:0]  width_cfg;
  logic        req_valid, req_write, req_burst, req_last;
  logic [3:0]  req_be;
  logic [1:0]  req_region;
  logic [28:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] req_rdata;
  logic        req_done;
  logic [28:0] lb_addr;
  logic        lb_rd, lb_wr;
  logic [3:0]  lb_be;
  logic [31:0] lb_wdata;
  logic [31:0] lb_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] rmodel(input logic [28:0] a);
    logic [7:0] x;
    x = a[7:0];
    return {x + 8'd3, x + 8'd2, x + 8'd1, x} ^ 32'hC3A55A3C;
  endfunction

  assign lb_rdata = rmodel(lb_addr);

  lbus_seq u_lbus_seq (
    .clk(clk), .rst_n(rst_n), .active_mode(active_mode), .wait_cfg(wait_cfg),
    .width_cfg(width_cfg), .req_valid(req_valid), .req_write(req_write),
    .req_be(req_be), .req_region(req_region), .req_burst(req_burst),
    .req_last(req_last), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .req_done(req_done), .lb_addr(lb_addr),
    .lb_rd(lb_rd), .lb_wr(lb_wr), .lb_be(lb_be), .lb_wdata(lb_wdata),
    .lb_rdata(lb_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request; expectations passed explicitly.
  task automatic run_txn(input logic wr, input logic [3:0] be, input logic [1:0] rg,
                         input logic [28:0] addr, input logic [31:0] wd,
                         input logic burst, input logic last,
                         input logic [28:0] ebase, input int ew, input int elg,
                         input int poke, input string note);
    int bpl, nsl, n, seen, done_c, c;
    int slots[4];
    logic [31:0] erd, word;
    logic [2:0]  sv_wait;
    logic [7:0]  sv_wid;
    bpl = 1 << elg; nsl = 4 >> elg; n = 0; erd = '0;
    sv_wait = wait_cfg; sv_wid = width_cfg;
    for (int s = 0; s < nsl; s++) begin
      logic u;
      u = 1'b0;
      for (int j = 0; j < bpl; j++) u = u | be[s*bpl + j];
      if (u) begin
        slots[n] = s; n++;
        word = rmodel(ebase + 29'(s*bpl));
        for (int j = 0; j < bpl; j++) erd[8*(s*bpl+j) +: 8] = word[8*j +: 8];
      end
    end
    req_write = wr; req_be = be; req_region = rg; req_addr = addr;
    req_wdata = wd; req_burst = burst; req_last = last; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    c = 1; seen = 0; done_c = -1;
    while (c <= 120 && done_c < 0) begin
      if (lb_rd || lb_wr) begin
        if (seen >= n) begin
          chk(1'b0, {"R5 extra strobe ", note}, 32'(seen), 32'(n));
        end else begin
          int s, exp_c;
          s = slots[seen];
          exp_c = 1 + seen*(ew+2) + ew + 1;
          chk(c == exp_c, {"R3 strobe cycle ", note}, 32'(c), 32'(exp_c));
          chk(lb_addr == ebase + 29'(s*bpl), {"R4 address ", note},
              32'(lb_addr), 32'(ebase + 29'(s*bpl)));
          chk(lb_wr == wr && lb_rd == !wr, {"R11 direction ", note},
              {30'd0, lb_wr, lb_rd}, {30'd0, wr, !wr});
          if (wr) begin
            logic [3:0] ebe;
            ebe = (be >> (s*bpl)) & 4'((1 << bpl) - 1);
            chk(lb_be == ebe, {"R6 lane enables ", note}, 32'(lb_be), 32'(ebe));
            chk(lb_wdata == (wd >> (8*s*bpl)), {"R6 write data ", note},
                lb_wdata, wd >> (8*s*bpl));
          end
        end
        seen++;
      end
      if (req_done) begin
        done_c = c;
        if (!wr) chk(req_rdata == erd, {"R7 read data ", note}, req_rdata, erd);
      end
      @(negedge clk);
      if (c == poke) begin
        req_valid = 1'b0;
        wait_cfg = sv_wait; width_cfg = sv_wid;
      end
      c++;
      if (c == poke) begin
        req_valid = 1'b1; req_addr = 29'h0ABCDE; req_be = 4'h1;
        req_write = !wr; wait_cfg = ~sv_wait; width_cfg = ~sv_wid;
      end
    end
    req_valid = 1'b0;
    wait_cfg = sv_wait; width_cfg = sv_wid;
    chk(seen == n, {"R5 strobe count ", note}, 32'(seen), 32'(n));
    if (n == 0)
      chk(done_c == 1, {"R5 empty request done ", note}, 32'(done_c), 32'd1);
    else
      chk(done_c == n*(ew+2) + 1, {"R8 done cycle ", note}, 32'(done_c),
          32'(n*(ew+2) + 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit quiet;
    rst_n = 1'b0; active_mode = 1'b1; wait_cfg = 3'd0; width_cfg = 8'hE4;
    req_valid = 1'b0; req_write = 1'b0; req_be = '0; req_region = '0;
    req_burst = 1'b0; req_last = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!lb_rd && !lb_wr && !req_done, "R1 strobes in reset",
        {29'd0, lb_rd, lb_wr, req_done}, 32'd0);
    chk(lb_addr == '0, "R1 address in reset", 32'(lb_addr), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!lb_rd && !lb_wr && !req_done, "R1 idle after reset",
        {29'd0, lb_rd, lb_wr, req_done}, 32'd0);

    // Passive mode.
    active_mode = 1'b0; req_write = 1'b1; req_be = 4'hF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (lb_rd || lb_wr || req_done) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R2 passive request ignored", {31'd0, quiet}, 32'd1);
    active_mode = 1'b1;
    run_txn(1'b1, 4'hF, 2'd1, 29'h000300, 32'h11223344, 1'b0, 1'b0,
            29'h000300, 0, 1, 0, "R2 after passive");

    // Sweep: region r width code r (3 is 32-bit).
    for (int w = 0; w < 8; w++) begin
      for (int r = 0; r < 4; r++) begin
        for (int b = 0; b < 16; b++) begin
          for (int d = 0; d < 2; d++) begin
            logic [28:0] a;
            logic [31:0] wd;
            a  = 29'h001000 + 29'((w*64 + r*16 + b) * 8);
            wd = 32'h9E3779B9 * 32'(w*128 + r*32 + b*2 + d + 1);
            wait_cfg = 3'(w);
            run_txn(d[0], 4'(b), 2'(r), a, wd, 1'b0, 1'b0, a, w,
                    (r == 3) ? 2 : r, 0, "sweep R4");
          end
        end
      end
    end

    // Pulse and configuration change during a transfer.
    wait_cfg = 3'd3; width_cfg = 8'hE4;
    run_txn(1'b0, 4'hF, 2'd0, 29'h002000, 32'h0, 1'b0, 1'b0,
            29'h002000, 3, 0, 2, "R10 R11 poke read");
    run_txn(1'b1, 4'hB, 2'd1, 29'h002100, 32'hCAFEF00D, 1'b0, 1'b0,
            29'h002100, 3, 1, 4, "R10 R11 poke write");

    // Burst of three beats in an 8-bit region.
    wait_cfg = 3'd2; width_cfg = 8'hE4;
    run_txn(1'b1, 4'hF, 2'd0, 29'h000100, 32'hA1B2C3D4, 1'b1, 1'b0,
            29'h000100, 2, 0, 0, "R9 beat0");
    wait_cfg = 3'd5; width_cfg = 8'hAA;
    run_txn(1'b1, 4'h6, 2'd2, 29'h01F000, 32'h55667788, 1'b1, 1'b0,
            29'h000104, 2, 0, 0, "R9 beat1");
    run_txn(1'b0, 4'hF, 2'd2, 29'h01F000, 32'h0, 1'b1, 1'b1,
            29'h000108, 2, 0, 0, "R9 beat2");
    run_txn(1'b0, 4'hF, 2'd2, 29'h000200, 32'h0, 1'b0, 1'b0,
            29'h000200, 5, 2, 0, "R9 after burst");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule